// File: doc/BRIEF.md
# Polled and Interrupt-Driven Word I/O Register Port

This block sits on a simple 16-bit processor bus as a peripheral. It gives software six word registers at even addresses. One register receives words from an input source. One holds words for an output sink. One is a general scratch word. Three are control words. The device side is two valid/ready streams, one inbound and one outbound. Each stream moves at most one word at a time.

Software can drive a transfer by polling status bits. It can also enable an interrupt line. For input, the arrival of a word sets a ready flag. For output, a start flag launches the transfer, and the sink accepting the word sets a done flag. The interrupt line stays high until software clears the flag that caused it. Clearing that flag is the acknowledge, and it re-arms the device for the next word.

Bus reads are combinational from the address. Bus writes take effect at the next rising clock edge.

Top module: `pio_regs`

## Requirements
- R1: After reset, every register reads as zero, `inReady` is 1, `outValid` is 0 and `irq` is 0.
- R2: The registers are decoded at word offsets from `BASE_ADDR`, which defaults to 0xFF00, with a step of 2 bytes. The map is: input data at +0x0, input control at +0x2, output data at +0x4, output control at +0x6, scratch at +0x8 and interrupt enable at +0xA. Any other address reads as 0, including odd addresses and addresses past +0xA. The scratch word stores all 16 bits on a write and returns them on a read.
- R3: When `inValid` and `inReady` are both high at a clock edge, the input data register takes `inData`. From the next cycle, bit 0 of the input control word reads 1 and `inReady` is low.
- R4: While bit 0 of the input control word is 1, `inReady` stays low and the input data register keeps its word. Bus writes to the input data register never change it.
- R5: A bus write to the input control word with bit 0 = 0 clears the ready flag, and `inReady` returns to 1 from the next cycle. A write with bit 0 = 1 leaves the flag unchanged.
- R6: A bus write of 1 to bit 0 of the output control word while no transfer is in progress starts a transfer. From the next cycle, `outValid` is 1 and `outData` equals the output data register.
- R7: When `outValid` and `outReady` are both high at a clock edge, bit 1 (done) of the output control word reads 1 from the next cycle and `outValid` drops. Bit 0 (start) stays 1.
- R8: While a transfer is in progress (start = 1, done = 0), bus writes to the output control word and to the output data register are ignored. `outValid` stays high and `outData` stays stable until the sink accepts the word.
- R9: When no transfer is in progress, a write to the output control word loads start from bit 0. A write with bit 1 = 0 clears done, and a write with bit 1 = 1 leaves done unchanged.
- R10: The interrupt enable word stores only bits 1:0, and its other bits read 0. `irq` = (input ready flag AND enable bit 0) OR (output done flag AND enable bit 1). `irq` stays high until software clears the flag or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 16 | Bus byte address |
| busWrEn | input | 1 | Bus write strobe, one cycle per write |
| busWrData | input | 16 | Bus write data |
| busRdData | output | 16 | Bus read data for `busAddr`, combinational |
| inValid | input | 1 | Input source offers a word |
| inData | input | 16 | Input source word |
| inReady | output | 1 | Block can take an input word |
| outValid | output | 1 | Output word is offered to the sink |
| outData | output | 16 | Output word |
| outReady | input | 1 | Sink takes the offered word |
| irq | output | 1 | Level interrupt request |

## Verification
The properties take for granted that the device streams keep to valid/ready rules. A pending flag may only change through the bus, so the "flag holds unless software clears it" checks assume that only `busWrEn` cycles touch control state. The stimulus keeps the bus write strobe to single-cycle pulses. It drives `inValid` and `outReady` only at falling edges. It also raises them only as isolated one-cycle offers, or holds them while the block is stalled, so that both sides stay inside these assumptions.

// File: rtl/pio_regs_pkg.sv
package pio_regs_pkg;

  localparam int NUM_REGS = 6;
  localparam int SEL_W    = 3;

  // Order of this enum is the address order of the register map
  typedef enum logic [SEL_W-1:0] {
    REG_IN_DATA  = 3'd0,
    REG_IN_CTL   = 3'd1,
    REG_OUT_DATA = 3'd2,
    REG_OUT_CTL  = 3'd3,
    REG_AUX      = 3'd4,
    REG_IRQ_EN   = 3'd5
  } regSel_e;

  typedef struct packed {
    logic    ldInData;
    logic    ldOutData;
    logic    ldAux;
    logic    rdHit;
    regSel_e rdSel;
  } dpStrobe_t;

endpackage

// File: rtl/pio_regs_ctrl.sv
module pio_regs_ctrl
  import pio_regs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 16'hFF00,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [1:0]        ctlWrBits,
  input  logic              inValid,
  output logic              inReady,
  output logic              outValid,
  input  logic              outReady,
  output logic              irq,
  output logic              inFull,
  output logic              outStart,
  output logic              outDone,
  output logic [1:0]        irqEn,
  output dpStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] BASE      = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN      = ADDR_W'(NUM_REGS * ADDR_STEP);
  localparam logic [ADDR_W-1:0] STEP_MASK = ADDR_W'(ADDR_STEP - 1);
  localparam int                STEP_LG   = $clog2(ADDR_STEP);

  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] idxFull;
  logic              hit;
  regSel_e           sel;
  logic              outBusy;
  logic              wrInCtl, wrOutCtl, wrIrqEn;

  always_comb begin
    offs    = busAddr - BASE;
    idxFull = offs >> STEP_LG;
    hit     = (offs < SPAN) && ((offs & STEP_MASK) == '0);
    sel     = hit ? regSel_e'(idxFull[SEL_W-1:0]) : REG_IN_DATA;
  end

  assign outBusy  = outStart & ~outDone;
  assign wrInCtl  = busWrEn && hit && (sel == REG_IN_CTL);
  assign wrOutCtl = busWrEn && hit && (sel == REG_OUT_CTL);
  assign wrIrqEn  = busWrEn && hit && (sel == REG_IRQ_EN);

  assign inReady  = ~inFull;
  assign outValid = outBusy;
  assign irq      = (inFull & irqEn[0]) | (outDone & irqEn[1]);

  always_comb begin
    strobe.ldInData  = inValid & inReady;
    strobe.ldOutData = busWrEn && hit && (sel == REG_OUT_DATA) && !outBusy;
    strobe.ldAux     = busWrEn && hit && (sel == REG_AUX);
    strobe.rdHit     = hit;
    strobe.rdSel     = sel;
  end

  // Input ready flag: set by the source, cleared only by software
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFull <= 1'b0;
    end else if (inValid && inReady) begin
      inFull <= 1'b1;
    end else if (wrInCtl && !ctlWrBits[0]) begin
      inFull <= 1'b0;
    end
  end

  // Output start/done flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outStart <= 1'b0;
      outDone  <= 1'b0;
    end else if (wrOutCtl && !outBusy) begin
      outStart <= ctlWrBits[0];
      outDone  <= outDone & ctlWrBits[1];
    end else if (outValid && outReady) begin
      outDone  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn <= 2'b00;
    end else if (wrIrqEn) begin
      irqEn <= ctlWrBits;
    end
  end

endmodule

// File: rtl/pio_regs_dp.sv
module pio_regs_dp
  import pio_regs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] inWord,
  input  logic              inFull,
  input  logic              outStart,
  input  logic              outDone,
  input  logic [1:0]        irqEn,
  output logic [DATA_W-1:0] outWord,
  output logic [DATA_W-1:0] busRdData
);

  logic [DATA_W-1:0] inReg, outReg, auxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg  <= '0;
      outReg <= '0;
      auxReg <= '0;
    end else begin
      if (strobe.ldInData)  inReg  <= inWord;
      if (strobe.ldOutData) outReg <= busWrData;
      if (strobe.ldAux)     auxReg <= busWrData;
    end
  end

  assign outWord = outReg;

  always_comb begin
    busRdData = '0;
    if (strobe.rdHit) begin
      unique case (strobe.rdSel)
        REG_IN_DATA:  busRdData = inReg;
        REG_IN_CTL:   busRdData = DATA_W'({inFull});
        REG_OUT_DATA: busRdData = outReg;
        REG_OUT_CTL:  busRdData = DATA_W'({outDone, outStart});
        REG_AUX:      busRdData = auxReg;
        REG_IRQ_EN:   busRdData = DATA_W'(irqEn);
        default:      busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_regs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BASE_ADDR = 16'hFF00,
  parameter int ADDR_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady,
  output logic              irq
);

  dpStrobe_t  strobe;
  logic       inFull, outStart, outDone;
  logic [1:0] irqEn;

  pio_regs_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .ctlWrBits(busWrData[1:0]), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .irq(irq),
    .inFull(inFull), .outStart(outStart), .outDone(outDone),
    .irqEn(irqEn), .strobe(strobe)
  );

  pio_regs_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .inWord(inData), .inFull(inFull), .outStart(outStart),
    .outDone(outDone), .irqEn(irqEn), .outWord(outData),
    .busRdData(busRdData)
  );

endmodule

// File: rtl/pio_regs_chk.sv
module pio_regs_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BASE_ADDR = 16'hFF00,
  parameter int ADDR_STEP = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady,
  input logic              irq
);

  logic clrIn;
  assign clrIn = busWrEn && (busAddr == ADDR_W'(BASE_ADDR + ADDR_STEP)) && !busWrData[0];

  AST_IN_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);  // R3

  AST_IN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !clrIn) |=> !inReady);  // R4

  AST_OUT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(busWrEn));  // R6

  AST_OUT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> !outValid);  // R7

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));  // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !busWrEn) |=> irq);  // R10

endmodule

bind pio_regs pio_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR), .ADDR_STEP(ADDR_STEP)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outReady(outReady), .irq(irq)
);

// File: tb/test_pio_regs.sv
module test_pio_regs;

  localparam logic [15:0] A_IN_DATA  = 16'hFF00;
  localparam logic [15:0] A_IN_CTL   = 16'hFF02;
  localparam logic [15:0] A_OUT_DATA = 16'hFF04;
  localparam logic [15:0] A_OUT_CTL  = 16'hFF06;
  localparam logic [15:0] A_AUX      = 16'hFF08;
  localparam logic [15:0] A_IRQ_EN   = 16'hFF0A;

  typedef struct packed {
    logic        isWr;
    logic [15:0] addr;
    logic [15:0] data;   // write data, or expected read data
    logic [3:0]  reqNum;
  } busVec_t;

  localparam int NVEC = 11;
  localparam busVec_t VECS [NVEC] = '{
    '{1'b1, A_AUX,      16'hA5C3, 4'd2},  // R2 scratch write
    '{1'b0, A_AUX,      16'hA5C3, 4'd2},  // R2 scratch read
    '{1'b1, A_IRQ_EN,   16'hFFFF, 4'd10}, // R10 only bits 1:0 kept
    '{1'b0, A_IRQ_EN,   16'h0003, 4'd10},
    '{1'b1, A_IRQ_EN,   16'h0000, 4'd10},
    '{1'b0, 16'hFF0C,   16'h0000, 4'd2},  // R2 past the map
    '{1'b0, 16'hFF09,   16'h0000, 4'd2},  // R2 odd address
    '{1'b0, 16'hFEFE,   16'h0000, 4'd2},  // R2 below the base
    '{1'b1, A_IN_DATA,  16'h1234, 4'd4},  // R4 bus cannot write input data
    '{1'b0, A_IN_DATA,  16'h0000, 4'd4},
    '{1'b1, A_OUT_DATA, 16'h5A5A, 4'd2}   // R2 output data write
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        inValid = 1'b0;
  logic [15:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic [15:0] outData;
  logic        outReady = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pio_regs i_pio_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic readCheck(input string req, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] d;
    busRead(a, d);
    check(req, d, exp);
  endtask

  // One-cycle offer on the input stream; returns inReady seen at the offer
  task automatic offerIn(input logic [15:0] w, output logic rdy);
    @(negedge clk);
    inValid = 1'b1; inData = w;
    #1 rdy = inReady;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic rdy;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    #1;
    check("R1 inReady", 16'(inReady), 16'h1);
    check("R1 outValid", 16'(outValid), 16'h0);
    check("R1 irq", 16'(irq), 16'h0);
    readCheck("R1 in ctl", A_IN_CTL, 16'h0);
    readCheck("R1 out ctl", A_OUT_CTL, 16'h0);
    readCheck("R1 in data", A_IN_DATA, 16'h0);

    // Table of bus vectors (R2, R4, R10)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) begin
        busWrite(VECS[i].addr, VECS[i].data);
      end else begin
        busRead(VECS[i].addr, d);
        check($sformatf("R%0d table row %0d", VECS[i].reqNum, i), d, VECS[i].data);
      end
    end
    readCheck("R2 out data", A_OUT_DATA, 16'h5A5A);

    // Input channel with interrupt enabled
    busWrite(A_IRQ_EN, 16'h0001);
    offerIn(16'hBEEF, rdy);
    check("R3 ready at offer", 16'(rdy), 16'h1);
    readCheck("R3 in data", A_IN_DATA, 16'hBEEF);
    readCheck("R3 in ctl", A_IN_CTL, 16'h0001);
    check("R3 inReady low", 16'(inReady), 16'h0);
    check("R10 irq on input", 16'(irq), 16'h1);
    offerIn(16'hC0DE, rdy);
    check("R4 ready while full", 16'(rdy), 16'h0);
    readCheck("R4 word kept", A_IN_DATA, 16'hBEEF);
    busWrite(A_IN_CTL, 16'h0001);
    readCheck("R5 write 1 no effect", A_IN_CTL, 16'h0001);
    check("R10 irq held", 16'(irq), 16'h1);
    busWrite(A_IN_CTL, 16'h0000);
    readCheck("R5 cleared", A_IN_CTL, 16'h0000);
    check("R5 inReady back", 16'(inReady), 16'h1);
    check("R10 irq dropped", 16'(irq), 16'h0);
    offerIn(16'hC0DE, rdy);
    readCheck("R3 second word", A_IN_DATA, 16'hC0DE);
    busWrite(A_IN_CTL, 16'h0000);

    // Output channel
    busWrite(A_IRQ_EN, 16'h0002);
    busWrite(A_OUT_DATA, 16'h7777);
    check("R6 idle before start", 16'(outValid), 16'h0);
    busWrite(A_OUT_CTL, 16'h0001);
    #1;
    check("R6 outValid", 16'(outValid), 16'h1);
    check("R6 outData", outData, 16'h7777);
    busWrite(A_OUT_DATA, 16'h1111);
    busWrite(A_OUT_CTL, 16'h0000);
    #1;
    check("R8 outData held", outData, 16'h7777);
    check("R8 outValid held", 16'(outValid), 16'h1);
    readCheck("R8 out data reg", A_OUT_DATA, 16'h7777);
    readCheck("R8 out ctl", A_OUT_CTL, 16'h0001);
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    #1;
    check("R7 outValid dropped", 16'(outValid), 16'h0);
    readCheck("R7 done set", A_OUT_CTL, 16'h0003);
    check("R10 irq on output", 16'(irq), 16'h1);
    busWrite(A_OUT_CTL, 16'h0003);
    readCheck("R9 done kept", A_OUT_CTL, 16'h0003);
    check("R9 irq kept", 16'(irq), 16'h1);
    busWrite(A_OUT_CTL, 16'h0000);
    readCheck("R9 cleared", A_OUT_CTL, 16'h0000);
    check("R9 irq released", 16'(irq), 16'h0);

    // Output done with its interrupt disabled
    busWrite(A_IRQ_EN, 16'h0000);
    busWrite(A_OUT_DATA, 16'h0F0F);
    busWrite(A_OUT_CTL, 16'h0001);
    @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    readCheck("R7 done again", A_OUT_CTL, 16'h0003);
    check("R10 irq gated", 16'(irq), 16'h0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule